// File: doc/BRIEF.md
# External Register Bus Bridge

This block connects an internal request/acknowledge port to an external 8-bit parallel register bus. That bus has a 16-bit address, a read strobe, a write strobe and four chip selects. All strobes and chip selects are active low. A requester asks for a byte or a 16-bit word access. The bridge then steps through address setup, strobe, optional wait and hold states, each one system clock long. It splits every word access into two byte transfers: the even address goes first and the odd address follows.

The number of wait states comes from a 3-bit configuration input. Waits stretch only the states in which a strobe is active. A second configuration input chooses how a word read is carried out:
- With the input low, the read strobe stays low across both bytes.
- With the input high, each byte gets its own read-strobe pulse, with one idle state between them.

The external data bus is modelled as three separate signals: data in, data out and output enable. Read data is sampled on the clock edge that ends each strobe pulse. A word result carries the even-address byte in its low half.

Top module: `xbus_bridge`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, the bridge is idle. All chip selects are high, both strobes are high, the output enable is low and the acknowledge is low.
- R2: With W configured wait states, a byte read holds a chip select low for 2+W cycles. It gives exactly one read-strobe pulse of 1+W cycles. The result is {8'h00, byte}, with the byte sampled in the last strobe cycle.
- R3: When split-strobe mode is off, a word read takes 3+2W cycles. It uses a single read-strobe pulse of 2+2W cycles. The even address is presented before the odd address, and the result is {odd byte, even byte}.
- R4: When split-strobe mode is on, a word read takes 4+2W cycles. It uses two read-strobe pulses of 1+W cycles each, the first at the even address and the second at the odd address.
- R5: A byte write takes 3+W cycles. It gives one write-strobe pulse of 1+W cycles. Write data wdata_i[7:0] is driven, with the output enable high, for every cycle in which the chip select is low.
- R6: A word write takes 5+2W cycles and gives two write-strobe pulses of 1+W cycles each. The even address receives wdata_i[7:0] first, and the odd address then receives wdata_i[15:8]. The split-strobe setting has no effect on writes.
- R7: The wait count W (0 to 7) is sampled when a request is accepted. It lengthens only the cycles in which a strobe is low.
- R8: A request drives low only chip select cs_sel_i (index 0 to 3), and only for the duration of its access. At most one chip select is ever low.
- R9: A word access drives address bit 0 to 0 for the first byte and to 1 for the second, whatever addr_i[0] is. A byte access uses addr_i unchanged. The address does not change in the cycle in which a strobe falls, nor while a write strobe stays low.
- R10: ack_o is high for exactly one cycle, namely the cycle after the final bus state, with all chip selects high. A request presented while an access is in progress, or in the acknowledge cycle, is ignored.
- R11: The two strobes are never low together, and a strobe is low only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one bus state per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken in an idle cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| cs_sel_i | input | 2 | Chip select index |
| addr_i | input | 16 | Access address |
| wdata_i | input | 16 | Write data; bits [7:0] go to the even byte |
| cfg_wait_i | input | 3 | Wait states added per strobe |
| cfg_split_i | input | 1 | Separate read-strobe pulse per byte on word reads |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with ack_o |
| bus_addr_o | output | 16 | External address |
| bus_cs_n_o | output | 4 | External chip selects, active low |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_d_i | input | 8 | External data in |
| bus_d_o | output | 8 | External data out |
| bus_d_oe_o | output | 1 | Drive enable for bus_d_o |

## Verification
The clock edge that samples req_i is the one that accepts the request. The bus outputs change from that edge, so the first bus state is visible in the following cycle. ack_o and rdata_o arrive in the cycle after the last state in which a chip select is low. The bench drives inputs and samples outputs at falling clock edges. Starting from the first falling edge after the accepting edge, it counts chip-select cycles, strobe pulses and strobe-low cycles until ack_o appears. It then compares those counts, the strobe addresses and the result against closed-form values in W. An external register file model returns data that depends on the address, so a byte fetched from the wrong address or in the wrong order shows up in the result.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    XB_IDLE,
    XB_SETUP,
    XB_STRB,
    XB_GAP,
    XB_HOLD
  } xb_state_e;
endpackage

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic              zero_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      we_i,
  input  logic      word_i,
  input  logic      split_i,
  input  logic      zero_i,
  output xb_state_e state_o,
  output logic      hi_o,
  output logic      load_o,
  output logic      dec_o,
  output logic      last_strb_o,
  output logic      done_o
);
  xb_state_e state_q, state_d;
  logic      hi_q, hi_d;

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      XB_IDLE: begin
        if (start_i) begin
          state_d = XB_SETUP;
          hi_d    = 1'b0;
        end
      end
      XB_SETUP: begin
        state_d = XB_STRB;
        load_o  = 1'b1;
      end
      XB_STRB: begin
        if (!zero_i) begin
          dec_o = 1'b1;
        end else if (word_i && !hi_q) begin
          hi_d = 1'b1;
          // writes and split reads release the strobe between bytes
          if (we_i || split_i) state_d = XB_GAP;
          else                 load_o  = 1'b1;
        end else if (we_i) begin
          state_d = XB_HOLD;
        end else begin
          state_d = XB_IDLE;
          done_o  = 1'b1;
        end
      end
      XB_GAP: begin
        state_d = XB_STRB;
        load_o  = 1'b1;
      end
      XB_HOLD: begin
        state_d = XB_IDLE;
        done_o  = 1'b1;
      end
      default: state_d = XB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XB_IDLE;
      hi_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
    end
  end

  assign state_o     = state_q;
  assign hi_o        = hi_q;
  assign last_strb_o = (state_q == XB_STRB) && zero_i;
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  xb_state_e           state_i,
  input  logic                hi_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [NUM_CS-1:0]   bus_cs_n_o,
  output logic                bus_rd_n_o,
  output logic                bus_wr_n_o,
  output logic [DATA_W-1:0]   bus_d_o,
  output logic                bus_d_oe_o
);
  logic active, strb;

  assign active = (state_i != XB_IDLE);
  assign strb   = (state_i == XB_STRB);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign bus_cs_n_o[i] = !(active && (sel_i == SEL_W'(i)));
  end

  assign bus_addr_o = word_i ? {addr_i[ADDR_W-1:1], hi_i} : addr_i;
  assign bus_rd_n_o = !(strb && !we_i);
  assign bus_wr_n_o = !(strb && we_i);
  assign bus_d_oe_o = active && we_i;
  assign bus_d_o    = hi_i ? wdata_i[2*DATA_W-1:DATA_W] : wdata_i[DATA_W-1:0];
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 3,
  localparam int SEL_W  = $clog2(NUM_CS),
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [SEL_W-1:0]  cs_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              cfg_split_i,
  output logic              ack_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [NUM_CS-1:0] bus_cs_n_o,
  output logic              bus_rd_n_o,
  output logic              bus_wr_n_o,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o
);
  xb_state_e         state;
  logic              hi, load, dec, zero, last_strb, done, start;
  logic              we_q, word_q, split_q, ack_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [WAIT_W-1:0] wait_q;
  logic [DATA_W-1:0] lo_q;

  // no acceptance in the acknowledge cycle
  assign start = req_i && (state == XB_IDLE) && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      split_q <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wait_q  <= '0;
    end else if (start) begin
      we_q    <= we_i;
      word_q  <= word_i;
      split_q <= cfg_split_i;
      sel_q   <= cs_sel_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wait_q  <= cfg_wait_i;
    end
  end

  xbus_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (wait_q),
    .dec_i      (dec),
    .zero_o     (zero)
  );

  xbus_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .we_i        (we_q),
    .word_i      (word_q),
    .split_i     (split_q),
    .zero_i      (zero),
    .state_o     (state),
    .hi_o        (hi),
    .load_o      (load),
    .dec_o       (dec),
    .last_strb_o (last_strb),
    .done_o      (done)
  );

  xbus_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_CS (NUM_CS),
    .SEL_W  (SEL_W)
  ) u_pins (
    .state_i    (state),
    .hi_i       (hi),
    .we_i       (we_q),
    .word_i     (word_q),
    .sel_i      (sel_q),
    .addr_i     (addr_q),
    .wdata_i    (wdata_q),
    .bus_addr_o (bus_addr_o),
    .bus_cs_n_o (bus_cs_n_o),
    .bus_rd_n_o (bus_rd_n_o),
    .bus_wr_n_o (bus_wr_n_o),
    .bus_d_o    (bus_d_o),
    .bus_d_oe_o (bus_d_oe_o)
  );

  // read capture on the edge ending each strobe pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= done;
      if (last_strb && !we_q) begin
        if (word_q && !hi) lo_q    <= bus_d_i;
        else if (word_q)   rdata_q <= {bus_d_i, lo_q};
        else               rdata_q <= {{DATA_W{1'b0}}, bus_d_i};
      end
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [NUM_CS-1:0] bus_cs_n_o,
  input logic              bus_rd_n_o,
  input logic              bus_wr_n_o,
  input logic              bus_d_oe_o
);
  // R8
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_cs_n_o));
  // R11
  strb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_n_o && !bus_wr_n_o));
  // R11
  strb_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_n_o || !bus_wr_n_o) |-> !(&bus_cs_n_o));
  // R9
  rd_addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_rd_n_o) |-> $stable(bus_addr_o));
  // R9
  wr_addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_wr_n_o) |-> $stable(bus_addr_o));
  // R9
  wr_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_n_o && $past(!bus_wr_n_o)) |-> $stable(bus_addr_o));
  // R5
  wr_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_wr_n_o) |-> bus_d_oe_o);
  // R5
  oe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_d_oe_o |-> !(&bus_cs_n_o));
  // R10
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R10
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (&bus_cs_n_o));
endmodule

bind xbus_bridge xbus_bridge_chk #(
  .ADDR_W (ADDR_W),
  .NUM_CS (NUM_CS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_o      (ack_o),
  .bus_addr_o (bus_addr_o),
  .bus_cs_n_o (bus_cs_n_o),
  .bus_rd_n_o (bus_rd_n_o),
  .bus_wr_n_o (bus_wr_n_o),
  .bus_d_oe_o (bus_d_oe_o)
);

// File: tb/sim_xbus_bridge.sv
`timescale 1ns/1ps
module sim_xbus_bridge;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0, cfg_split_i = 1'b0;
  logic [1:0]  cs_sel_i = '0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [2:0]  cfg_wait_i = '0;
  logic        ack_o, bus_rd_n_o, bus_wr_n_o, bus_d_oe_o;
  logic [15:0] rdata_o, bus_addr_o;
  logic [3:0]  bus_cs_n_o;
  logic [7:0]  bus_d_i, bus_d_o;
  logic [7:0]  mem [16];
  int          nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  // external register file model
  always_comb bus_d_i = bus_rd_n_o ? 8'hEE : (mem[bus_addr_o[3:0]] ^ bus_addr_o[15:8]);

  xbus_bridge u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .word_i(word_i),
    .cs_sel_i(cs_sel_i), .addr_i(addr_i), .wdata_i(wdata_i), .cfg_wait_i(cfg_wait_i),
    .cfg_split_i(cfg_split_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .bus_addr_o(bus_addr_o), .bus_cs_n_o(bus_cs_n_o), .bus_rd_n_o(bus_rd_n_o),
    .bus_wr_n_o(bus_wr_n_o), .bus_d_i(bus_d_i), .bus_d_o(bus_d_o), .bus_d_oe_o(bus_d_oe_o)
  );

  // {we, word, split, wait[2:0], sel[1:0], addr[15:0], wdata[15:0]}
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 16'h1203, 16'h0000},
    {1'b0, 1'b0, 1'b0, 3'd3, 2'd1, 16'h00A6, 16'h0000},
    {1'b0, 1'b1, 1'b0, 3'd0, 2'd2, 16'h0044, 16'h0000},
    {1'b0, 1'b1, 1'b0, 3'd2, 2'd3, 16'h0109, 16'h0000},
    {1'b0, 1'b1, 1'b1, 3'd0, 2'd0, 16'h300A, 16'h0000},
    {1'b0, 1'b1, 1'b1, 3'd1, 2'd1, 16'h000E, 16'h0000},
    {1'b0, 1'b1, 1'b1, 3'd7, 2'd2, 16'h5502, 16'h0000},
    {1'b1, 1'b0, 1'b0, 3'd0, 2'd2, 16'h0005, 16'h00C3},
    {1'b1, 1'b0, 1'b0, 3'd4, 2'd3, 16'h000C, 16'h0071},
    {1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 16'h0002, 16'hBEEF},
    {1'b1, 1'b1, 1'b0, 3'd2, 2'd1, 16'h0007, 16'h1234},
    {1'b1, 1'b1, 1'b1, 3'd0, 2'd3, 16'h0008, 16'hA55A},
    {1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 16'h0006, 16'h0000},
    {1'b0, 1'b0, 1'b0, 3'd1, 2'd1, 16'h0005, 16'h0000}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_acc(input logic [39:0] v, input bit poke);
    logic        we, word, split;
    int          w, st, rdl, rdp, wrl, wrp, oec, n, csbad, bytes;
    logic [1:0]  sel;
    logic [15:0] a, wd, ea, oa, fa, la, exp_rd;
    logic        prd, pwr, seen;
    logic [7:0]  keep;
    string       tag;
    we = v[39]; word = v[38]; split = v[37]; w = int'(v[36:34]);
    sel = v[33:32]; a = v[31:16]; wd = v[15:0];
    st = 0; rdl = 0; rdp = 0; wrl = 0; wrp = 0; oec = 0; n = 0; csbad = 0;
    prd = 1'b1; pwr = 1'b1; seen = 1'b0; fa = '0; la = '0;
    bytes = word ? 2 : 1;
    ea = word ? {a[15:1], 1'b0} : a;
    oa = word ? {a[15:1], 1'b1} : a;
    tag = we ? (word ? "R6" : "R5") : (!word ? "R2" : (split ? "R4" : "R3"));
    exp_rd = word ? {mem[oa[3:0]] ^ oa[15:8], mem[ea[3:0]] ^ ea[15:8]}
                  : {8'h00, mem[ea[3:0]] ^ ea[15:8]};
    keep = mem[15];
    @(negedge clk);
    req_i = 1'b1; we_i = we; word_i = word; cs_sel_i = sel; addr_i = a; wdata_i = wd;
    cfg_wait_i = 3'(w); cfg_split_i = split;
    @(negedge clk);
    req_i = 1'b0;
    cfg_wait_i = 3'd5; cfg_split_i = ~split;  // R7: latched at acceptance
    while (!ack_o && n < 200) begin
      if (~bus_cs_n_o != (4'b0001 << sel)) csbad++;
      st++;
      if (!bus_rd_n_o) begin
        rdl++; if (prd) rdp++;
        if (!seen) fa = bus_addr_o;
        seen = 1'b1; la = bus_addr_o;
      end
      if (!bus_wr_n_o) begin
        wrl++; if (pwr) wrp++;
        if (!seen) fa = bus_addr_o;
        seen = 1'b1; la = bus_addr_o;
        mem[bus_addr_o[3:0]] = bus_d_o;
      end
      if (bus_d_oe_o) oec++;
      prd = bus_rd_n_o; pwr = bus_wr_n_o;
      if (poke && n == 2) begin
        req_i = 1'b1; we_i = 1'b1; word_i = 1'b0; addr_i = 16'h000F; wdata_i = 16'h005A;
      end else req_i = 1'b0;
      n++;
      @(negedge clk);
    end
    chk("R10", "ack seen", {31'd0, ack_o}, 32'd1);
    chk("R10", "cs idle at ack", {28'd0, bus_cs_n_o}, 32'hF);
    if (!word)        chk(tag, "states", st, we ? 3 + w : 2 + w);
    else if (we)      chk(tag, "states", st, 5 + 2 * w);
    else              chk(tag, "states", st, split ? 4 + 2 * w : 3 + 2 * w);
    chk("R8", "chip select", csbad, 0);
    chk("R9", "first strobe addr", fa, ea);
    chk("R9", "last strobe addr", la, oa);
    if (we) begin
      chk(tag, "write pulses", wrp, bytes);
      chk("R7", "write low cycles", wrl, (1 + w) * bytes);
      chk(tag, "read pulses", rdp, 0);
      chk("R5", "oe cycles", oec, st);
      chk(tag, "even byte", mem[ea[3:0]], wd[7:0]);
      if (word) chk("R6", "odd byte", mem[oa[3:0]], wd[15:8]);
    end else begin
      chk(tag, "read pulses", rdp, (word && split) ? 2 : 1);
      chk("R7", "read low cycles", rdl, (1 + w) * bytes);
      chk(tag, "write pulses", wrp, 0);
      chk(tag, "oe cycles", oec, 0);
      chk(tag, "rdata", rdata_o, exp_rd);
    end
    if (poke) begin
      req_i = 1'b1; we_i = 1'b1; word_i = 1'b0; addr_i = 16'h000F;  // during ack cycle
      @(negedge clk);
      req_i = 1'b0;
      for (int k = 0; k < 4; k++) begin
        chk("R10", "ignored request", {28'd0, bus_cs_n_o}, 32'hF);
        @(negedge clk);
      end
      chk("R10", "no stray write", mem[15], keep);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "cs in reset", {28'd0, bus_cs_n_o}, 32'hF);
    chk("R1", "strobes in reset", {30'd0, bus_rd_n_o, bus_wr_n_o}, 32'h3);
    chk("R1", "oe/ack in reset", {30'd0, bus_d_oe_o, ack_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {26'd0, bus_cs_n_o, bus_d_oe_o, ack_o}, 32'h3C);
    for (int i = 0; i < NV; i++) run_acc(VEC[i], 1'b0);
    // R10: requests during busy and ack cycles are dropped
    run_acc({1'b0, 1'b0, 1'b0, 3'd5, 2'd0, 16'h0003, 16'h0000}, 1'b1);
    // R3 wait extremes on unaligned word read
    run_acc({1'b0, 1'b1, 1'b0, 3'd7, 2'd3, 16'hFF0F, 16'h0000}, 1'b0);
    // R6 max wait write then back-to-back readback
    run_acc({1'b1, 1'b1, 1'b0, 3'd7, 2'd2, 16'h000B, 16'h6C39}, 1'b0);
    run_acc({1'b0, 1'b1, 1'b1, 3'd0, 2'd2, 16'h000A, 16'h0000}, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule